// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block is the address engine of one DMA channel. Software programs a line length, a line count and a line-to-line stride, all counted in 32-bit words. It then writes a byte start address, and that write launches the channel. The engine presents one word address at a time to a downstream data mover. It advances only when the mover accepts the word. It steps through each line and then jumps by the stride to the start of the next line. After the last word of the last line it raises a completion event and returns to idle.

A line length of zero selects loop mode, which suits double-buffered streaming. The engine walks a region of stride × (line count + 1) words and then wraps back to the start address. It raises an event each time it finishes either half of that region. Loop mode runs only while both loop-enable bits of the channel are set. A stop input halts the channel at once and raises no event. Events set a status bit that software clears by writing one. The interrupt line is the status bit gated by an enable bit.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, busy, wordReq, intStatus and irq are all 0.
- R2: A write to register 0 stores regWrData[31:2] as the word start address and starts the channel. On the next cycle busy and wordReq are 1 and wordAddr equals that word address.
- R3: In normal mode (line length, register 1, not zero) the channel issues line length consecutive addresses per line. It issues register-2 + 1 lines, and each line starts register-3 (stride) words after the previous one.
- R4: A line count of 0 in register 2 gives exactly one line.
- R5: In normal mode, intStatus is set on the edge that accepts the last word of the last line, and busy falls on that same edge. No event is raised before that word.
- R6: Bits of register 4 drive the outputs: bit 4 drives burstMode (1 = 4-word bursts) and bit 5 drives dirToDev (1 = memory to device).
- R7: With line length 0 and both loop bits set (register 7 bits CHAN_ID and CHAN_ID+16), the address climbs from the start through stride × (count + 1) words, returns to the start address and keeps going.
- R8: In loop mode, intStatus is set on accepting the last word of the first half of the region, and again on accepting the last word of the region.
- R9: A start with line length 0 and the loop bits not both set is ignored, and busy stays 0. Clearing the loop bits while looping lets the channel finish the current region and then go idle.
- R10: Writing register 6 with bit CHAN_ID = 1 clears intStatus. Writing it with that bit = 0 leaves intStatus unchanged.
- R11: irq is 1 exactly when intStatus is 1 and the enable bit (register 5, bit CHAN_ID) is 1.
- R12: stopReq = 1 drops busy on the next edge and raises no event.
- R13: While wordAck is 0, wordAddr holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select (0 start addr, 1 line length, 2 line count, 3 stride, 4 control, 5 irq enable, 6 status clear, 7 loop enables) |
| regWrData | input | 32 | Register write data |
| stopReq | input | 1 | Halt channel immediately, no event |
| wordAck | input | 1 | Data mover accepts the current word |
| wordReq | output | 1 | Word request toward the data mover |
| wordAddr | output | 30 | Current 32-bit-word address |
| burstMode | output | 1 | 1 selects 4-word bursts |
| dirToDev | output | 1 | 1 = memory to device, 0 = device to memory |
| busy | output | 1 | Channel active |
| intStatus | output | 1 | Event status bit |
| irq | output | 1 | Interrupt output |

## Verification
The hardest state to reach is the second pass of a loop after software has disarmed it. The channel must already have wrapped once, software must have cleared the loop bits while it was still active, and the channel must then run on to the region end and stop. The bench gets there by handing out acknowledges one word at a time. Between acknowledges it writes the status-clear and loop-enable registers, so it can observe each half-buffer event, the wrap to the start address and the final drop of busy at a known word.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [2:0] {
    SEL_BASE   = 3'd0,
    SEL_LINE   = 3'd1,
    SEL_COUNT  = 3'd2,
    SEL_STRIDE = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_INTEN  = 3'd5,
    SEL_INTCLR = 3'd6,
    SEL_LOOP   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic load;
    logic stepWord;
    logic stepLine;
    logic wrap;
  } dpStrobe_t;
endpackage

// File: rtl/dma2d_datapath.sv
module dma2d_datapath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LEN_W-1:0]  lineLen,
  input  logic [LEN_W-1:0]  lineCnt,
  input  logic [LEN_W-1:0]  stride,
  output logic [ADDR_W-1:0] curAddr,
  output logic              lineDone,
  output logic              lastLine,
  output logic              halfHit,
  output logic              regionEnd
);
  localparam int OFF_W = 2 * LEN_W + 1;

  logic [ADDR_W-1:0] lineBase;
  logic [LEN_W-1:0]  xCnt, yCnt;
  logic [OFF_W-1:0]  offset;
  logic [OFF_W-1:0]  regionWords, regionLast, halfLast;

  assign regionWords = OFF_W'(stride) * (OFF_W'(lineCnt) + OFF_W'(1));
  assign regionLast  = regionWords - OFF_W'(1);
  assign halfLast    = (regionWords >> 1) - OFF_W'(1);

  assign lineDone  = (xCnt == LEN_W'(lineLen - LEN_W'(1)));
  assign lastLine  = (yCnt == lineCnt);
  assign halfHit   = (offset == halfLast);
  assign regionEnd = (offset == regionLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      lineBase <= '0;
      xCnt     <= '0;
      yCnt     <= '0;
      offset   <= '0;
    end else if (strb.load) begin
      curAddr  <= loadAddr;
      lineBase <= loadAddr;
      xCnt     <= '0;
      yCnt     <= '0;
      offset   <= '0;
    end else if (strb.wrap) begin
      curAddr <= baseAddr;
      offset  <= '0;
    end else if (strb.stepLine) begin
      lineBase <= lineBase + ADDR_W'(stride);
      curAddr  <= lineBase + ADDR_W'(stride);
      xCnt     <= '0;
      yCnt     <= yCnt + LEN_W'(1);
    end else if (strb.stepWord) begin
      curAddr <= curAddr + ADDR_W'(1);
      xCnt    <= xCnt + LEN_W'(1);
      offset  <= offset + OFF_W'(1);
    end
  end

  assert_word_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepWord && !strb.load && !strb.wrap && !strb.stepLine) |=> curAddr == $past(curAddr) + ADDR_W'(1));
  assert_line_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepLine && !strb.load && !strb.wrap) |=> (xCnt == '0) && (yCnt == $past(yCnt) + LEN_W'(1)));
  assert_wrap_base_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrap && !strb.load) |=> curAddr == $past(baseAddr));
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (strb == '0) |=> $stable(curAddr));
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
#(
  parameter int ADDR_W  = 30,
  parameter int LEN_W   = 16,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              stopReq,
  input  logic              wordAck,
  input  logic              lineDone,
  input  logic              lastLine,
  input  logic              halfHit,
  input  logic              regionEnd,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] loadAddr,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [LEN_W-1:0]  lineLen,
  output logic [LEN_W-1:0]  lineCnt,
  output logic [LEN_W-1:0]  stride,
  output logic              busy,
  output logic              burstMode,
  output logic              dirToDev,
  output logic              intStatus,
  output logic              irq
);
  localparam int LOOP_HI = CHAN_ID + 16;

  logic busyQ, loopModeQ, intEnQ, loopLoQ, loopHiQ;
  logic loopArm, startReq, start, accept, evt, goIdle;

  function automatic logic wrHit(input regSel_e s);
    return regWrEn && (regSel == s);
  endfunction

  assign loopArm  = loopLoQ && loopHiQ;
  assign loadAddr = regWrData[ADDR_W+1:2];
  assign startReq = wrHit(SEL_BASE);
  assign start    = startReq && !stopReq && ((lineLen != '0) || loopArm);
  assign accept   = busyQ && !stopReq && wordAck;

  always_comb begin
    strb   = '0;
    evt    = 1'b0;
    goIdle = 1'b0;
    if (start) begin
      strb.load = 1'b1;
    end else if (accept) begin
      if (loopModeQ) begin
        if (regionEnd) begin
          strb.wrap = 1'b1;
          evt       = 1'b1;
          goIdle    = !loopArm;
        end else begin
          strb.stepWord = 1'b1;
          evt           = halfHit;
        end
      end else if (lineDone) begin
        if (lastLine) begin
          evt    = 1'b1;
          goIdle = 1'b1;
        end else begin
          strb.stepLine = 1'b1;
        end
      end else begin
        strb.stepWord = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr  <= '0;
      lineLen   <= '0;
      lineCnt   <= '0;
      stride    <= '0;
      burstMode <= 1'b0;
      dirToDev  <= 1'b0;
      intEnQ    <= 1'b0;
      loopLoQ   <= 1'b0;
      loopHiQ   <= 1'b0;
      intStatus <= 1'b0;
      busyQ     <= 1'b0;
      loopModeQ <= 1'b0;
    end else begin
      if (startReq)          baseAddr <= loadAddr;
      if (wrHit(SEL_LINE))   lineLen  <= regWrData[LEN_W-1:0];
      if (wrHit(SEL_COUNT))  lineCnt  <= regWrData[LEN_W-1:0];
      if (wrHit(SEL_STRIDE)) stride   <= regWrData[LEN_W-1:0];
      if (wrHit(SEL_CTRL)) begin
        burstMode <= regWrData[4];
        dirToDev  <= regWrData[5];
      end
      if (wrHit(SEL_INTEN)) intEnQ <= regWrData[CHAN_ID];
      if (wrHit(SEL_LOOP)) begin
        loopLoQ <= regWrData[CHAN_ID];
        loopHiQ <= regWrData[LOOP_HI];
      end
      if (evt)                                          intStatus <= 1'b1;
      else if (wrHit(SEL_INTCLR) && regWrData[CHAN_ID]) intStatus <= 1'b0;
      if (start) begin
        busyQ     <= 1'b1;
        loopModeQ <= (lineLen == '0);
      end else if (stopReq || goIdle) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy = busyQ;
  assign irq  = intStatus && intEnQ;

  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busy);
  assert_event_needs_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStatus) |-> $past(busyQ));
  assert_stop_no_event_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !intStatus) |=> !intStatus);
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intStatus);
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int LEN_W   = 16,
  parameter int CHAN_ID = 0,
  localparam int ADDR_W = BUS_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  input  logic              stopReq,
  input  logic              wordAck,
  output logic              wordReq,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              burstMode,
  output logic              dirToDev,
  output logic              busy,
  output logic              intStatus,
  output logic              irq
);
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] loadAddr, baseAddr;
  logic [LEN_W-1:0]  lineLen, lineCnt, stride;
  logic              lineDone, lastLine, halfHit, regionEnd;

  dma2d_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHAN_ID(CHAN_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .stopReq(stopReq), .wordAck(wordAck),
    .lineDone(lineDone), .lastLine(lastLine), .halfHit(halfHit),
    .regionEnd(regionEnd), .strb(strb), .loadAddr(loadAddr),
    .baseAddr(baseAddr), .lineLen(lineLen), .lineCnt(lineCnt),
    .stride(stride), .busy(busy), .burstMode(burstMode),
    .dirToDev(dirToDev), .intStatus(intStatus), .irq(irq)
  );

  dma2d_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadAddr(loadAddr),
    .baseAddr(baseAddr), .lineLen(lineLen), .lineCnt(lineCnt),
    .stride(stride), .curAddr(wordAddr), .lineDone(lineDone),
    .lastLine(lastLine), .halfHit(halfHit), .regionEnd(regionEnd)
  );

  assign wordReq = busy;
endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = '0;
  logic [31:0] regWrData = '0;
  logic stopReq = 1'b0;
  logic wordAck = 1'b0;
  logic wordReq, burstMode, dirToDev, busy, intStatus, irq;
  logic [29:0] wordAddr;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dma2d_addr_gen uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .stopReq(stopReq), .wordAck(wordAck),
    .wordReq(wordReq), .wordAddr(wordAddr), .burstMode(burstMode),
    .dirToDev(dirToDev), .busy(busy), .intStatus(intStatus), .irq(irq)
  );

  // byte base, line length, line count, stride, expected words, expected last word address
  localparam logic [127:0] VEC [4] = '{
    {32'h0000_1000, 16'd4, 16'd2, 16'd6,  16'd12, 32'h0000_040F},
    {32'h0000_2000, 16'd1, 16'd0, 16'd1,  16'd1,  32'h0000_0800},
    {32'h0000_0080, 16'd3, 16'd3, 16'd3,  16'd12, 32'h0000_002B},
    {32'h0000_0104, 16'd2, 16'd1, 16'd10, 16'd4,  32'h0000_004C}
  };

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic ackOne();
    wordAck = 1'b1;
    @(negedge clk);
    wordAck = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !wordReq && !intStatus && !irq, "R1 reset", {busy, wordReq, intStatus, irq}, 0);

    // R6 control bits
    wr(3'd4, 32'h30);
    check(burstMode && dirToDev, "R6 burst+dir", {burstMode, dirToDev}, 2'b11);
    wr(3'd4, 32'h10);
    check(burstMode && !dirToDev, "R6 burst only", {burstMode, dirToDev}, 2'b10);

    // R2 R3 R4 R5 vector table walk
    for (int v = 0; v < 4; v++) begin
      logic [31:0] bb; logic [15:0] xl, yl, st, ew; logic [31:0] el;
      int mism, early, words;
      logic [29:0] lastSeen;
      {bb, xl, yl, st, ew, el} = VEC[v];
      mism = 0; early = 0; words = 0; lastSeen = '0;
      wr(3'd6, 32'h1);
      wr(3'd1, {16'd0, xl});
      wr(3'd2, {16'd0, yl});
      wr(3'd3, {16'd0, st});
      wr(3'd0, bb);
      check(busy && wordReq && wordAddr == bb[31:2], "R2 start addr", wordAddr, bb[31:2]);
      for (int y = 0; y <= int'(yl); y++) begin
        for (int x = 0; x < int'(xl); x++) begin
          if (wordAddr != 30'(bb[31:2] + 32'(y) * 32'(st) + 32'(x))) mism++;
          if (intStatus || !busy) early++;
          lastSeen = wordAddr;
          words++;
          wordAck = 1'b1;
          @(negedge clk);
        end
      end
      wordAck = 1'b0;
      check(mism == 0, "R3 address walk", mism, 0);
      check(words == int'(ew) && lastSeen == el[29:0], "R4 word count and last addr", lastSeen, el[29:0]);
      check(early == 0 && !busy && intStatus, "R5 single completion", {early[3:0], busy, intStatus}, 1);
    end

    // R10 write-one-to-clear
    wr(3'd6, 32'h0);
    check(intStatus, "R10 zero write keeps status", intStatus, 1);
    // R11 irq gating
    check(!irq, "R11 irq masked", irq, 0);
    wr(3'd5, 32'h1);
    check(irq, "R11 irq enabled", irq, 1);
    wr(3'd6, 32'h1);
    check(!intStatus && !irq, "R10 one write clears", {intStatus, irq}, 0);

    // R13 hold without ack, R12 stop
    wr(3'd1, 32'd4); wr(3'd2, 32'd2); wr(3'd3, 32'd6);
    wr(3'd0, 32'h0000_0400);
    ackOne(); ackOne();
    repeat (3) @(negedge clk);
    check(wordAddr == 30'h102 && busy, "R13 hold without ack", wordAddr, 30'h102);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check(!busy && !wordReq, "R12 stop halts", busy, 0);
    wordAck = 1'b1;
    repeat (12) @(negedge clk);
    wordAck = 1'b0;
    check(!intStatus && !busy, "R12 no event after stop", intStatus, 0);

    // R9 loop start ignored when not armed
    wr(3'd1, 32'd0); wr(3'd2, 32'd3); wr(3'd3, 32'd2);
    wr(3'd7, 32'h0000_0001);
    wr(3'd0, 32'h0000_0400);
    check(!busy, "R9 unarmed loop ignored", busy, 0);

    // R7 R8 loop mode: region 8 words, half 4
    wr(3'd7, 32'h0001_0001);
    wr(3'd0, 32'h0000_0400);
    begin
      int mism = 0;
      for (int k = 0; k < 8; k++) begin
        if (wordAddr != 30'(32'h100 + k)) mism++;
        ackOne();
        if (k == 2) check(!intStatus, "R8 no event before half", intStatus, 0);
        if (k == 3) begin
          check(intStatus, "R8 first half event", intStatus, 1);
          wr(3'd6, 32'h1);
        end
      end
      check(mism == 0, "R7 loop addresses", mism, 0);
    end
    check(busy && wordAddr == 30'h100, "R7 wrap to start", wordAddr, 30'h100);
    check(intStatus, "R8 region end event", intStatus, 1);

    // R9 disarm while looping: finish region then idle
    wr(3'd7, 32'h0);
    wr(3'd6, 32'h1);
    for (int k = 0; k < 7; k++) ackOne();
    check(busy && wordAddr == 30'h107 && intStatus, "R9 still running after disarm", wordAddr, 30'h107);
    ackOne();
    check(!busy && !wordReq, "R9 idle at region end", busy, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule